// File: doc/BRIEF.md
# I2C Byte Shift Register with Filtered Bus Sampling

This block is the byte-wide data path for one side of an I2C bus interface. A single 8-bit register holds either the byte about to be sent or the byte that has just arrived. The raw SCL and SDA levels are first passed through a synchroniser and a noise-rejection stage. A shift clock is then derived from the cleaned SCL, one system clock later. Incoming bits are captured at the rising event of that shift clock.

When transmitting, the most significant bit appears first on SDA. The line is pulled low for a 0 and released for a 1, and it only changes while SCL is low. The bits seen on the line are shifted back in at bit 0, so after a full byte the register holds what was actually on the bus.

A processor-side write is accepted only while the interface enable is set. An accepted write loads the byte and clears the bit counter. If the block is in master mode, the same write also starts an SCL generator that produces eight clock pulses and then releases the line. The read port always shows the register contents. Start/stop generation, arbitration, acknowledge and address matching are left to neighbouring logic.

Top module: `i2cByteShifter`

## Requirements
- R1: While `busEnable` is 0, a write pulse on `wrEn` leaves `rdData` and `bitCount` unchanged, and SCL edges do not shift the register.
- R2: `rdData` presents the register contents at all times, including while `busEnable` is 0.
- R3: In transmit mode (`txMode`=1), bit 7 of the written byte appears on SDA before the first SCL rise, and the following bits follow in descending order, one per SCL pulse. `sdaLow`=1 pulls the line low for a 0 bit and `sdaLow`=0 releases it for a 1 bit. `sdaLow` does not change while the shift clock is high, except at a write, a change of `txMode`, or the end of a byte. After eight pulses, `rdData` equals the byte observed on the line.
- R4: In receive mode, each bit sampled at an SCL rise enters at bit 0 while earlier bits move one place toward bit 7. `bitCount` counts the bits received since the last accepted write.
- R5: An accepted write (`wrEn`=1 and `busEnable`=1) sets `bitCount` to 0 on the next clock and loads `wrData` into the register.
- R6: An accepted write with `masterMode`=1 makes `sclLow` produce exactly eight low pulses of `HALF_PERIOD` cycles each, separated by release phases of the same length. After that, `sclLow` stays 0. With `masterMode`=0, `sclLow` stays 0.
- R7: A level on SCL that lasts a single system clock is rejected and causes no shift. A level lasting two or more clocks is accepted.
- R8: `byteDone` is high for exactly one clock when the eighth bit is shifted in, and `bitCount` wraps from 7 to 0 at that same edge.
- R9: `sdaLow` is 0 whenever `txMode` is 0, and also once a transmitted byte has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busEnable | input | 1 | Interface enable; gates writes and shifting |
| masterMode | input | 1 | 1 = this side generates SCL after a write |
| txMode | input | 1 | 1 = transmit byte on SDA, 0 = receive |
| wrEn | input | 1 | Processor write strobe |
| wrData | input | 8 | Byte to load |
| rdData | output | 8 | Current register contents |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| sclLow | output | 1 | 1 = pull SCL low (open-drain) |
| sdaLow | output | 1 | 1 = pull SDA low (open-drain) |
| bitCount | output | 3 | Bits shifted since last accepted write |
| byteDone | output | 1 | One-cycle pulse after the eighth bit |

## Verification
The hardest condition to reach is a partial byte interrupted by a write while the interface is disabled and then by an accepted write. The counter and register must freeze in the first case and restart in the second, which can only be seen between bus bits. The bench drives SCL and SDA as a wired-AND model from its own external-device controls. It stops the receive sequence after three bits, toggles the enable, and issues writes at that point. The same bus model is used to insert SCL pulses of one and two clocks, which exercises the noise filter.

// File: rtl/i2cShiftPkg.sv
package i2cShiftPkg;
  // Strobes issued by the control unit to the datapath, at most one per cycle
  typedef struct packed {
    logic load;      // accepted processor write
    logic shiftIn;   // shift clock rising event: shift left, capture SDA
    logic driveNext; // shift clock falling event: present next output bit
  } shiftStrobe_t;
endpackage

// File: rtl/i2cLineFilter.sv
module i2cLineFilter #(
  parameter int   SYNC_STAGES = 2,
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= {CHAIN_W{RESET_LEVEL}};
      filtOut <= RESET_LEVEL;
    end else begin
      chain <= {chain[CHAIN_W-2:0], rawIn};
      // Output follows only when two consecutive samples agree
      if (chain[CHAIN_W-1] == chain[CHAIN_W-2])
        filtOut <= chain[CHAIN_W-1];
    end
  end

  // R7: a change on the output must be backed by the newest agreeing sample
  p_filter_agree_r7: assert property (@(posedge clk) disable iff (!rstN)
    (filtOut != $past(filtOut)) |-> ($past(chain[CHAIN_W-2]) == filtOut));
endmodule

// File: rtl/i2cShiftCtrl.sv
module i2cShiftCtrl
  import i2cShiftPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_PERIOD = 8,
  parameter int CNT_W       = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busEnable,
  input  logic             masterMode,
  input  logic             wrEn,
  input  logic             sclFilt,
  output shiftStrobe_t     strb,
  output logic             shClk,
  output logic [CNT_W-1:0] bitCount,
  output logic             byteDone,
  output logic             xferActive,
  output logic             sclLow
);
  localparam int               HALF_W   = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [HALF_W-1:0] HALF_END = HALF_W'(HALF_PERIOD - 1);

  logic              accepted;
  logic              riseEv;
  logic              fallEv;
  logic              doneNext;
  logic              genActive;
  logic [HALF_W-1:0] halfCnt;

  always_comb begin
    accepted       = wrEn && busEnable;
    riseEv         = busEnable && sclFilt && !shClk;
    fallEv         = busEnable && !sclFilt && shClk;
    doneNext       = !accepted && riseEv && (bitCount == LAST_BIT);
    strb.load      = accepted;
    strb.shiftIn   = riseEv && !accepted;
    strb.driveNext = fallEv && !accepted;
  end

  // Shift clock: filtered SCL delayed by one system clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shClk <= 1'b1;
    else       shClk <= sclFilt;
  end

  // Bit counter and completion pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= doneNext;
      if (accepted)
        bitCount <= '0;
      else if (riseEv)
        bitCount <= (bitCount == LAST_BIT) ? '0 : bitCount + 1'b1;
    end
  end

  // Transfer window: opened by a write, closed by the final bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            xferActive <= 1'b0;
    else if (!busEnable)  xferActive <= 1'b0;
    else if (accepted)    xferActive <= 1'b1;
    else if (doneNext)    xferActive <= 1'b0;
  end

  // Master SCL generator: alternate low/release phases until the byte ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genActive <= 1'b0;
      sclLow    <= 1'b0;
      halfCnt   <= '0;
    end else if (!busEnable || doneNext) begin
      genActive <= 1'b0;
      sclLow    <= 1'b0;
      halfCnt   <= '0;
    end else if (accepted) begin
      genActive <= masterMode;
      sclLow    <= masterMode;
      halfCnt   <= '0;
    end else if (genActive) begin
      if (halfCnt == HALF_END) begin
        halfCnt <= '0;
        sclLow  <= !sclLow;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // R5: an accepted write restarts the count
  p_count_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (bitCount == '0));
  // R8: completion coincides with the wrap from the last bit
  p_done_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> ((bitCount == '0) && ($past(bitCount) == LAST_BIT)));
  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);
  // R6: SCL is only pulled inside an open transfer
  p_scl_owner_r6: assert property (@(posedge clk) disable iff (!rstN)
    sclLow |-> xferActive);
  // R6: SCL is released when the byte completes
  p_scl_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> !sclLow);
endmodule

// File: rtl/i2cShiftData.sv
module i2cShiftData
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobe_t      strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdaFilt,
  input  logic              txMode,
  input  logic              xferActive,
  input  logic              sclLevel,
  output logic [DATA_W-1:0] rdData,
  output logic              sdaLow
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shReg;
  logic              outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      outBit <= 1'b1;
    end else if (strb.load) begin
      shReg  <= wrData;
      outBit <= wrData[MSB];
    end else if (strb.shiftIn) begin
      shReg  <= {shReg[MSB-1:0], sdaFilt};
    end else if (strb.driveNext) begin
      outBit <= shReg[MSB];
    end
  end

  always_comb begin
    rdData = shReg;
    sdaLow = txMode && xferActive && !outBit;
  end

  // R9: receive mode never pulls SDA
  p_sda_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    !txMode |-> !sdaLow);
  // R3: SDA holds while the shift clock stays high
  p_sda_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel && $past(sclLevel) && !$past(strb.load) && $stable(txMode)
      && $stable(xferActive)) |-> $stable(sdaLow));
endmodule

// File: rtl/i2cByteShifter.sv
module i2cByteShifter
  import i2cShiftPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_PERIOD = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEnable,
  input  logic              masterMode,
  input  logic              txMode,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclLow,
  output logic              sdaLow,
  output logic [CNT_W-1:0]  bitCount,
  output logic              byteDone
);
  localparam int LINES = 2; // index 0 = SCL, 1 = SDA

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] filtLines;
  shiftStrobe_t     strb;
  logic             shClk;
  logic             xferActive;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : g_filter
    i2cLineFilter #(
      .SYNC_STAGES(SYNC_STAGES),
      .RESET_LEVEL(1'b1)
    ) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawLines[g]),
      .filtOut(filtLines[g])
    );
  end

  i2cShiftCtrl #(
    .DATA_W     (DATA_W),
    .HALF_PERIOD(HALF_PERIOD),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busEnable (busEnable),
    .masterMode(masterMode),
    .wrEn      (wrEn),
    .sclFilt   (filtLines[0]),
    .strb      (strb),
    .shClk     (shClk),
    .bitCount  (bitCount),
    .byteDone  (byteDone),
    .xferActive(xferActive),
    .sclLow    (sclLow)
  );

  i2cShiftData #(
    .DATA_W(DATA_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .sdaFilt   (filtLines[1]),
    .txMode    (txMode),
    .xferActive(xferActive),
    .sclLevel  (shClk),
    .rdData    (rdData),
    .sdaLow    (sdaLow)
  );

  // R1: a write while disabled leaves the register untouched
  p_write_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busEnable) |=> $stable(rdData));
endmodule

// File: tb/i2cByteShifter_test.sv
`timescale 1ns/1ps
module i2cByteShifter_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busEnable = 1'b0;
  logic       masterMode = 1'b0;
  logic       txMode = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       sclLow, sdaLow, byteDone;
  logic [2:0] bitCount;
  logic       extSclLow = 1'b0;
  logic       extSdaLow = 1'b0;
  logic       sclLine, sdaLine;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // monitor counters (written only by monitors)
  int  doneCnt = 0;
  int  sclLowCyc = 0;
  int  sdaLowCyc = 0;
  int  riseCnt = 0;
  logic [7:0] capBits = 8'h00;
  logic prevScl = 1'b1;

  assign sclLine = !(sclLow || extSclLow);
  assign sdaLine = !(sdaLow || extSdaLow);

  always #10 clk = !clk; // 50 MHz

  i2cByteShifter uut (
    .clk(clk), .rstN(rstN), .busEnable(busEnable), .masterMode(masterMode),
    .txMode(txMode), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclLow(sclLow), .sdaLow(sdaLow),
    .bitCount(bitCount), .byteDone(byteDone)
  );

  always @(negedge clk) begin
    if (byteDone) doneCnt++;
    if (sclLow)   sclLowCyc++;
    if (sdaLow)   sdaLowCyc++;
    if (sclLine && !prevScl) begin
      riseCnt++;
      capBits = {capBits[6:0], sdaLine};
    end
    prevScl = sclLine;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cpuWrite(input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rxBit(input logic b);
    extSdaLow = !b;
    waitCyc(4);
    extSclLow = 1'b0;
    waitCyc(8);
    extSclLow = 1'b1;
    waitCyc(4);
  endtask

  task automatic rxByte(input logic [7:0] b);
    extSclLow = 1'b1;
    waitCyc(8);
    for (int i = 7; i >= 0; i--) rxBit(b[i]);
    extSdaLow = 1'b0;
    waitCyc(8);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d0, s0, sd0, r0;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);
    // reset state
    check(rdData == 8'h00 && bitCount == 3'd0, "R2 reset contents", rdData, 0);
    check(!sclLow && !sdaLow && !byteDone, "R9 reset lines released",
          {sclLow, sdaLow, byteDone}, 0);

    // receive sweep, slave mode
    busEnable = 1'b1; masterMode = 1'b0; txMode = 1'b0;
    s0 = sclLowCyc; sd0 = sdaLowCyc;
    for (int b = 0; b < 256; b++) begin
      cpuWrite(8'h00);
      d0 = doneCnt;
      rxByte(8'(b));
      check(rdData == 8'(b), "R4 received byte", rdData, b);
      check(doneCnt - d0 == 1 && bitCount == 3'd0, "R8 one completion pulse",
            doneCnt - d0, 1);
    end
    check(sclLowCyc == s0, "R6 no SCL drive in slave mode", sclLowCyc - s0, 0);
    check(sdaLowCyc == sd0, "R9 SDA released while receiving", sdaLowCyc - sd0, 0);

    // partial byte, disabled write, then accepted write
    cpuWrite(8'h00);
    rxBit(1'b1); rxBit(1'b0); rxBit(1'b1);
    check(bitCount == 3'd3, "R4 partial count", bitCount, 3);
    check(rdData == 8'h05, "R4 partial shift at bit 0", rdData, 8'h05);
    busEnable = 1'b0;
    cpuWrite(8'hC3);
    waitCyc(2);
    check(rdData == 8'h05, "R1 disabled write ignored", rdData, 8'h05);
    check(bitCount == 3'd3, "R1 disabled write keeps count", bitCount, 3);
    rxBit(1'b1);
    check(rdData == 8'h05 && bitCount == 3'd3, "R1 no shift while disabled",
          rdData, 8'h05);
    check(rdData == 8'h05, "R2 read while disabled", rdData, 8'h05);
    busEnable = 1'b1;
    waitCyc(2);
    cpuWrite(8'h3C);
    waitCyc(1);
    check(bitCount == 3'd0, "R5 write clears count", bitCount, 0);
    check(rdData == 8'h3C, "R5 write loads byte", rdData, 8'h3C);

    // glitch rejection on SCL (SCL held low by external device)
    extSdaLow = 1'b0;
    waitCyc(6);
    @(posedge clk); #1; extSclLow = 1'b0;
    @(posedge clk); #1; extSclLow = 1'b1;
    waitCyc(10);
    check(bitCount == 3'd0 && rdData == 8'h3C, "R7 single-cycle pulse rejected",
          bitCount, 0);
    @(posedge clk); #1; extSclLow = 1'b0;
    @(posedge clk);
    @(posedge clk); #1; extSclLow = 1'b1;
    waitCyc(10);
    check(bitCount == 3'd1 && rdData == 8'h79, "R7 two-cycle pulse accepted",
          rdData, 8'h79);

    // transmit sweep, master mode
    masterMode = 1'b1; txMode = 1'b1;
    extSclLow = 1'b0; extSdaLow = 1'b0;
    waitCyc(12);
    for (int b = 0; b < 256; b++) begin
      r0 = riseCnt;
      cpuWrite(8'(b));
      waitCyc(200);
      check(riseCnt - r0 == 8 && !sclLow, "R6 eight SCL pulses then release",
            riseCnt - r0, 8);
      check(capBits == 8'(b), "R3 MSB-first bits on SDA", capBits, b);
      check(rdData == 8'(b), "R3 echoed byte in register", rdData, b);
      check(!sdaLow, "R9 SDA released after byte", sdaLow, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule